// File: doc/BRIEF.md
# SCSI Controller Interrupt Cause Register

This block records why a SCSI protocol controller raised an interrupt. The bus sequencer and the command decoder send it single-cycle event strobes. The block also takes the current operating role (disconnected, initiator or target), the ATN level sampled during selection, and a control bit that suppresses bus-reset reporting. Each event sets one bit in an 8-bit sticky cause register. The interrupt request line is high whenever any cause bit is set.

The meaning of several bits depends on the role. A strobe that belongs to the initiator side is dropped while the device acts as target, and the reverse. Selection is reported in one of two bits, chosen by the sampled ATN level. The host reads the register through `cause_o`, which always shows the stored bits. A read strobe clears the register and, after `CLR_LATENCY` cycles, sends a one-cycle clear pulse to the two companion status registers. An event that arrives in the same cycle as the read is kept for the next read.

Top module: `scsi_irq_cause`

## Requirements
- R1: While `rst_ni` is low, and on the clock edge after `sync_clr_i` is high, every cause bit and `irq_o` are 0. `sync_clr_i` wins over any event strobe in the same cycle.
- R2: `bus_rst_i` sets bit 7 when `rst_rpt_off_i` is 0. When `rst_rpt_off_i` is 1 it sets no bit.
- R3: Bit 6 is set when `cmd_valid_i` is high and either `cmd_illegal_i` is 1 or `cmd_role_i` differs from `role_i`. A legal command for the current role sets no bit. Role codes: 00 disconnected, 01 initiator, 10 target.
- R4: Bit 5 is set by `tgt_end_i` in the target role, and by `ini_free_i` or `ini_tmo_i` in the initiator role. These strobes set no bit in any other role.
- R5: Bit 4 is set by `tgt_atn_i` in the target role and by `ini_phase_i` in the initiator role. These strobes set no bit in any other role.
- R6: Bit 3 is set by `tgt_done_i` in the target role, and by `ini_sel_ok_i`, `ini_cmd_ok_i` or `ini_msgin_i` in the initiator role. These strobes set no bit in any other role.
- R7: In any role, `sel_end_i` sets bit 1 if `sel_atn_i` is 1 and bit 0 if `sel_atn_i` is 0. `resel_end_i` sets bit 2.
- R8: Cause bits are sticky. Events in different cycles accumulate by OR until a read or a clear.
- R9: `irq_o` is 1 in exactly the cycles in which at least one cause bit is set.
- R10: A cycle with `rd_i` high shows the pre-read bits on `cause_o`. After that edge only the bits set by events in the read cycle remain.
- R11: `stat_clr_o` and `seq_clr_o` are each high for exactly one cycle per read. With `CLR_LATENCY`=1 that is the cycle after `rd_i`; with 0 it is the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_clr_i | input | 1 | Synchronous chip reset |
| role_i | input | 2 | Current role: 00 disconnected, 01 initiator, 10 target |
| rst_rpt_off_i | input | 1 | Suppresses bus-reset reporting |
| bus_rst_i | input | 1 | Bus reset detected |
| cmd_valid_i | input | 1 | Command decoded |
| cmd_illegal_i | input | 1 | Decoded opcode is illegal |
| cmd_role_i | input | 2 | Role that the decoded opcode belongs to |
| tgt_end_i | input | 1 | Target: terminate or command-complete sequence left the bus |
| tgt_atn_i | input | 1 | Target: initiator asserted ATN |
| tgt_done_i | input | 1 | Target: target command completed |
| ini_free_i | input | 1 | Initiator: target disconnected |
| ini_tmo_i | input | 1 | Initiator: selection or reselection timeout |
| ini_phase_i | input | 1 | Initiator: target requests an information transfer phase |
| ini_sel_ok_i | input | 1 | Initiator: selection succeeded |
| ini_cmd_ok_i | input | 1 | Initiator: command completed |
| ini_msgin_i | input | 1 | Initiator: message-in requested after a transfer command |
| sel_end_i | input | 1 | Selection phase ended, device selected |
| sel_atn_i | input | 1 | ATN level sampled during selection |
| resel_end_i | input | 1 | Reselection phase ended |
| rd_i | input | 1 | Host read strobe |
| cause_o | output | 8 | Cause bits |
| irq_o | output | 1 | Interrupt request |
| stat_clr_o | output | 1 | Clear pulse to the status register |
| seq_clr_o | output | 1 | Clear pulse to the sequence status register |

## Verification
The bench builds the block with `CLR_LATENCY` at 1, its default. At that setting the companion clear pulse lands on the cycle after the read, so it can be checked apart from the read data and the same-cycle event.

The vector table drives every strobe under each role, including the strobes that must be ignored. The directed tests cover accumulation across cycles, an event that coincides with a read, a synchronous clear that coincides with an event, and an asynchronous reset taken in the middle of a run.

// File: rtl/scsi_icr_pkg.sv
package scsi_icr_pkg;
  localparam int unsigned CAUSE_W = 8;
  localparam int unsigned ROLE_W  = 2;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_DISC = 2'b00,
    ROLE_INIT = 2'b01,
    ROLE_TGT  = 2'b10
  } role_e;

  // bit positions are decoded by host software
  localparam int unsigned B_BUSRST = 7;
  localparam int unsigned B_BADCMD = 6;
  localparam int unsigned B_DISC   = 5;
  localparam int unsigned B_SVCREQ = 4;
  localparam int unsigned B_DONE   = 3;
  localparam int unsigned B_RESEL  = 2;
  localparam int unsigned B_SELATN = 1;
  localparam int unsigned B_SEL    = 0;
endpackage

// File: rtl/icr_event_map.sv
module icr_event_map
  import scsi_icr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ROLE_W-1:0]  role_i,
  input  logic               rst_rpt_off_i,
  input  logic               bus_rst_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_illegal_i,
  input  logic [ROLE_W-1:0]  cmd_role_i,
  input  logic               tgt_end_i,
  input  logic               tgt_atn_i,
  input  logic               tgt_done_i,
  input  logic               ini_free_i,
  input  logic               ini_tmo_i,
  input  logic               ini_phase_i,
  input  logic               ini_sel_ok_i,
  input  logic               ini_cmd_ok_i,
  input  logic               ini_msgin_i,
  input  logic               sel_end_i,
  input  logic               sel_atn_i,
  input  logic               resel_end_i,
  output logic [CAUSE_W-1:0] set_o
);
  logic is_tgt, is_ini;

  assign is_tgt = (role_i == ROLE_TGT);
  assign is_ini = (role_i == ROLE_INIT);

  always_comb begin
    set_o           = '0;
    set_o[B_BUSRST] = bus_rst_i & ~rst_rpt_off_i;
    set_o[B_BADCMD] = cmd_valid_i & (cmd_illegal_i | (cmd_role_i != role_i));
    set_o[B_DISC]   = (is_tgt & tgt_end_i) | (is_ini & (ini_free_i | ini_tmo_i));
    set_o[B_SVCREQ] = (is_tgt & tgt_atn_i) | (is_ini & ini_phase_i);
    set_o[B_DONE]   = (is_tgt & tgt_done_i)
                    | (is_ini & (ini_sel_ok_i | ini_cmd_ok_i | ini_msgin_i));
    set_o[B_RESEL]  = resel_end_i;
    set_o[B_SELATN] = sel_end_i & sel_atn_i;
    set_o[B_SEL]    = sel_end_i & ~sel_atn_i;
  end

  a_r2_rst_report_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rpt_off_i |-> !set_o[B_BUSRST]);

  a_r4_disc_role_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == ROLE_DISC) |-> (set_o[B_DISC:B_DONE] == '0));
endmodule

// File: rtl/icr_cause_reg.sv
module icr_cause_reg
  import scsi_icr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_clr_i,
  input  logic               rd_i,
  input  logic [CAUSE_W-1:0] set_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               irq_q;

  // a read keeps only the events that arrive in the read cycle
  always_comb begin
    if (sync_clr_i)  cause_d = '0;
    else if (rd_i)   cause_d = set_i;
    else             cause_d = cause_q | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= |cause_d;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = irq_q;

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !sync_clr_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sync_clr_i) |=> (cause_q == $past(set_i)));

  a_r1_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (cause_q == '0 && !irq_o));

  a_r9_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cause_q != '0));
endmodule

// File: rtl/icr_clr_pulse.sv
module icr_clr_pulse #(
  parameter int unsigned LATENCY = 1,
  parameter int unsigned N_CLR   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  output logic [N_CLR-1:0] clr_o
);
  logic pulse;

  generate
    if (LATENCY == 0) begin : g_comb
      assign pulse = rd_i;
    end else begin : g_reg
      logic pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= rd_i;
      end
      assign pulse = pulse_q;

      a_r11_clr_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> (clr_o == {N_CLR{1'b1}}));
      a_r11_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> (clr_o == '0));
    end
  endgenerate

  assign clr_o = {N_CLR{pulse}};
endmodule

// File: rtl/scsi_irq_cause.sv
module scsi_irq_cause
  import scsi_icr_pkg::*;
#(
  parameter int unsigned CLR_LATENCY = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_clr_i,
  input  logic [ROLE_W-1:0]  role_i,
  input  logic               rst_rpt_off_i,
  input  logic               bus_rst_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_illegal_i,
  input  logic [ROLE_W-1:0]  cmd_role_i,
  input  logic               tgt_end_i,
  input  logic               tgt_atn_i,
  input  logic               tgt_done_i,
  input  logic               ini_free_i,
  input  logic               ini_tmo_i,
  input  logic               ini_phase_i,
  input  logic               ini_sel_ok_i,
  input  logic               ini_cmd_ok_i,
  input  logic               ini_msgin_i,
  input  logic               sel_end_i,
  input  logic               sel_atn_i,
  input  logic               resel_end_i,
  input  logic               rd_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o,
  output logic               stat_clr_o,
  output logic               seq_clr_o
);
  localparam int unsigned N_CLR = 2;

  logic [CAUSE_W-1:0] set_vec;
  logic [N_CLR-1:0]   clr_vec;

  icr_event_map u_map (
    .clk_i, .rst_ni, .role_i, .rst_rpt_off_i, .bus_rst_i,
    .cmd_valid_i, .cmd_illegal_i, .cmd_role_i,
    .tgt_end_i, .tgt_atn_i, .tgt_done_i,
    .ini_free_i, .ini_tmo_i, .ini_phase_i, .ini_sel_ok_i, .ini_cmd_ok_i, .ini_msgin_i,
    .sel_end_i, .sel_atn_i, .resel_end_i,
    .set_o (set_vec)
  );

  icr_cause_reg u_reg (
    .clk_i, .rst_ni, .sync_clr_i, .rd_i,
    .set_i   (set_vec),
    .cause_o (cause_o),
    .irq_o   (irq_o)
  );

  icr_clr_pulse #(.LATENCY(CLR_LATENCY), .N_CLR(N_CLR)) u_clr (
    .clk_i, .rst_ni, .rd_i,
    .clr_o (clr_vec)
  );

  assign stat_clr_o = clr_vec[0];
  assign seq_clr_o  = clr_vec[1];
endmodule

// File: tb/scsi_irq_cause_tb.sv
module scsi_irq_cause_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_clr = 0, rst_off = 0, sel_atn = 0, rd = 0;
  logic [1:0] role = 0, cmd_role = 0;
  logic [13:0] stb = '0;
  logic [7:0] cause;
  logic irq, stat_clr, seq_clr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_irq_cause u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_clr_i(sync_clr), .role_i(role),
    .rst_rpt_off_i(rst_off), .bus_rst_i(stb[0]), .cmd_valid_i(stb[1]),
    .cmd_illegal_i(stb[2]), .cmd_role_i(cmd_role), .tgt_end_i(stb[3]),
    .tgt_atn_i(stb[4]), .tgt_done_i(stb[5]), .ini_free_i(stb[6]),
    .ini_tmo_i(stb[7]), .ini_phase_i(stb[8]), .ini_sel_ok_i(stb[9]),
    .ini_cmd_ok_i(stb[10]), .ini_msgin_i(stb[11]), .sel_end_i(stb[12]),
    .sel_atn_i(sel_atn), .resel_end_i(stb[13]), .rd_i(rd),
    .cause_o(cause), .irq_o(irq), .stat_clr_o(stat_clr), .seq_clr_o(seq_clr)
  );

  // {role, cmd_role, rst_off, sel_atn, 2'b0, expected cause, 2'b0, strobes}
  localparam logic [31:0] VEC [N_VEC] = '{
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h80, 2'b00, 14'h0001}, // R2
    {2'b10, 2'b10, 1'b1, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0001}, // R2 suppressed
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h40, 2'b00, 14'h0006}, // R3 illegal
    {2'b01, 2'b10, 1'b0, 1'b0, 2'b00, 8'h40, 2'b00, 14'h0002}, // R3 wrong role
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0002}, // R3 legal
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h20, 2'b00, 14'h0008}, // R4
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0008}, // R4 ignored
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h20, 2'b00, 14'h0080}, // R4 timeout
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0040}, // R4 ignored
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h10, 2'b00, 14'h0010}, // R5
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h10, 2'b00, 14'h0100}, // R5
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0010}, // R5 ignored
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h08, 2'b00, 14'h0020}, // R6
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h08, 2'b00, 14'h0800}, // R6 msg-in
    {2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 8'h08, 2'b00, 14'h0600}, // R6 sel+cmd
    {2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 8'h02, 2'b00, 14'h1000}, // R7 atn
    {2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 8'h01, 2'b00, 14'h1000}, // R7 no atn
    {2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 8'h04, 2'b00, 14'h2000}, // R7 resel
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 8'h98, 2'b00, 14'h0031}, // R2 R5 R6 mix
    {2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 8'h00, 2'b00, 14'h0100}  // R5 disconnected
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobes are driven for one cycle starting at a falling edge
  task automatic fire(input logic [13:0] s);
    @(negedge clk); stb = s;
    @(posedge clk); #1; stb = '0;
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset cause", cause, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      role = VEC[i][31:30]; cmd_role = VEC[i][29:28];
      rst_off = VEC[i][27]; sel_atn = VEC[i][26];
      fire(VEC[i][13:0]);
      check($sformatf("vec%0d cause", i), cause, VEC[i][23:16]);
      check($sformatf("vec%0d R9 irq", i), {7'b0, irq}, {7'b0, |VEC[i][23:16]});
      do_read();
    end

    // R8 accumulation across cycles
    @(negedge clk); role = 2'b10; rst_off = 0;
    fire(14'h0010);
    fire(14'h0020);
    check("R8 accumulate", cause, 8'h18);

    // R10 read with same-cycle event, R11 clear pulse
    @(negedge clk); rd = 1'b1; stb = 14'h0001;
    #1;
    check("R10 read data", cause, 8'h18);
    check("R11 no early clear", {6'b0, stat_clr, seq_clr}, 8'h00);
    @(posedge clk); #1; rd = 1'b0; stb = '0;
    check("R10 event kept", cause, 8'h80);
    check("R11 clear pulse", {6'b0, stat_clr, seq_clr}, 8'h03);
    @(posedge clk); #1;
    check("R11 pulse single", {6'b0, stat_clr, seq_clr}, 8'h00);
    check("R8 kept", cause, 8'h80);
    do_read();
    check("R10 cleared", cause, 8'h00);
    check("R9 irq low", {7'b0, irq}, 8'h00);

    // R1 sync clear beats event
    fire(14'h0010);
    @(negedge clk); sync_clr = 1'b1; stb = 14'h0001;
    @(posedge clk); #1; sync_clr = 1'b0; stb = '0;
    check("R1 sync clear", cause, 8'h00);
    check("R1 sync irq", {7'b0, irq}, 8'h00);

    // R1 async reset mid-run
    fire(14'h0020);
    check("R6 pre-reset", cause, 8'h08);
    @(negedge clk); rst_ni = 1'b0; #1;
    check("R1 async reset", cause, 8'h00);
    check("R1 async irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule